// File: doc/BRIEF.md
# Multi-Cycle Operand Address Sequencer

This block resolves where an 8-bit processor instruction's operand lives, and what that operand is. A single `start` pulse presents the opcode, the program counter, both index registers, the accumulator and the carry flag. The block decodes the opcode into one of twelve addressing schemes, an implied scheme, or an unassigned code. It then walks through the byte reads that the scheme needs on a single-byte memory read port. That port has a request/valid handshake and any latency.

When the walk is complete, `done` pulses for one cycle. With it come the 16-bit effective address, the operand byte, the program counter advanced past the operand bytes, and a flag marking an unassigned opcode. Multi-byte operands arrive most-significant byte first. The carry flag enters the index sum only in the absolute-indexed and pointer-then-Y schemes. Branch offsets use a sign-magnitude-like rule: an offset byte `b` above 127 yields `base + 127 - b`.

Top module: `eff_addr_gen`

## Requirements
- R1: Opcodes whose low nibble is 0 and whose high nibble is odd decode as relative. 0x6C decodes as pointer-indirect. 0x96 and 0xB6 decode as zero-page+Y. 0xBE decodes as absolute+Y. 0x02 is unassigned, 0xEA is implied, 0x0A uses the accumulator, and 0xA9 is immediate.
- R2: Two-byte operands (absolute, absolute+X/Y, pointer-indirect) are read from `pc` and then `pc+1`. The first byte becomes address bits 15:8 and the second becomes bits 7:0. `pc_out` is `pc+2`.
- R3: For absolute+X/Y, `ea` is the 16-bit operand plus the index plus carry, modulo 2^16. `operand` is the byte read at `ea`.
- R4: For zero-page, zero-page+X and zero-page+Y, one byte is read at `pc`. `ea` is that byte plus the index, with no carry, as a 16-bit sum that does not wrap into page zero. `operand` is the byte at `ea`, and `pc_out` is `pc+1`.
- R5: For the X-then-pointer scheme, `ea` is the operand byte plus X as a 16-bit sum. The byte read at `ea`, zero-extended, is the address of a second read. That second read returns `operand`. Carry is unused, and three reads are made in total.
- R6: For the pointer-then-Y scheme, the byte at the zero-extended operand byte is read. `ea` is that byte plus Y plus carry, and `operand` is the byte at `ea`.
- R7: For pointer-indirect, the 16-bit operand is a pointer `p`. `ea` is built with the byte at `p` as bits 15:8 and the byte at `p+1` as bits 7:0, and `operand` is the byte at `ea`. Five reads are made.
- R8: For relative, the offset byte `b` is read at `pc`, and `pc` is the base. `ea` is `pc+b` when `b` is 127 or less, and `pc+127-b` otherwise, modulo 2^16. `operand` is 0 and `pc_out` is `pc+1`.
- R9: In accumulator mode, `ea` is 0, `operand` is A, `pc_out` is `pc`, and no read is made. In immediate mode, `ea` is 0, `operand` is the byte at `pc`, `pc_out` is `pc+1`, and exactly one read is made.
- R10: Implied and unassigned opcodes raise `done` on the clock edge after `start`, with `ea` 0, `operand` 0, `pc_out` equal to `pc`, and no reads. `bad_mode` is 1 only for an unassigned opcode.
- R11: `start` is ignored while a walk is in progress, and inputs are sampled only when `start` is accepted. `done` lasts one cycle unless a new implied walk completes at once. Outputs stay stable between `done` pulses. `mem_req` holds with a stable `mem_addr` until `mem_rvalid`, and is low in the cycle `done` is high.
- R12: After reset, `done`, `mem_req`, `bad_mode`, `ea`, `operand` and `pc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| opcode | input | 8 | Instruction opcode |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| a_in | input | 8 | Accumulator |
| carry_in | input | 1 | Carry flag |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | 16 | Read address |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| operand | output | 8 | Resolved operand value |
| pc_out | output | 16 | Program counter past the operand |
| bad_mode | output | 1 | Opcode has no addressing scheme |

## Verification
Two events can fall in the same cycle: a `done` pulse and the acceptance of the next `start`. The bench provokes this by driving each new `start` in the very cycle where it first sees `done`, including chains of implied opcodes that each finish one edge after they begin. Every result is then compared with values computed from the rules above, and the `done` pulse width is checked whenever no new walk follows. A separate case pulses `start` with scrambled inputs in the middle of a pointer walk and checks that the original result is unchanged.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [3:0] {
        M_NONE, M_IMPL, M_ACC, M_IMM, M_ABS, M_ABX, M_ABY, M_IND,
        M_PREX, M_POSTY, M_REL, M_ZP, M_ZPX, M_ZPY
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_B0, ST_B1, ST_P0, ST_P1, ST_FIN, ST_DEREF
    } step_e;

    typedef struct packed {
        amode_e mode;
        logic   wide;
        logic   fast;
    } mode_info_t;

    function automatic addr_t zext(input byte_t b);
        return addr_t'(b);
    endfunction

    function automatic amode_e op_mode(input byte_t op);
        logic [NIB_W-1:0] hi, lo;
        logic             odd;
        amode_e           m;
        hi  = op[DATA_W-1:NIB_W];
        lo  = op[NIB_W-1:0];
        odd = hi[0];
        m   = M_NONE;
        case (lo)
            4'h0: begin
                if (odd) m = M_REL;
                else begin
                    case (hi)
                        4'h0, 4'h4, 4'h6:  m = M_IMPL;
                        4'h2:              m = M_ABS;
                        4'hA, 4'hC, 4'hE:  m = M_IMM;
                        default:           m = M_NONE;
                    endcase
                end
            end
            4'h1: m = odd ? M_POSTY : M_PREX;
            4'h2: m = (hi == 4'hA) ? M_IMM : M_NONE;
            4'h4: begin
                case (hi)
                    4'h2, 4'h8, 4'hA, 4'hC, 4'hE: m = M_ZP;
                    4'h9, 4'hB:                   m = M_ZPX;
                    default:                      m = M_NONE;
                endcase
            end
            4'h5: m = odd ? M_ZPX : M_ZP;
            4'h6: m = (hi == 4'h9 || hi == 4'hB) ? M_ZPY : (odd ? M_ZPX : M_ZP);
            4'h8: m = M_IMPL;
            4'h9: m = odd ? M_ABY : ((hi == 4'h8) ? M_NONE : M_IMM);
            4'hA: begin
                if (!hi[NIB_W-1]) m = odd ? M_NONE : M_ACC;
                else              m = (hi == 4'hD || hi == 4'hF) ? M_NONE : M_IMPL;
            end
            4'hC: begin
                if (hi == 4'h6)             m = M_IND;
                else if (hi == 4'hB)        m = M_ABX;
                else if (odd || hi == 4'h0) m = M_NONE;
                else                        m = M_ABS;
            end
            4'hD: m = odd ? M_ABX : M_ABS;
            4'hE: begin
                if (hi == 4'h9)      m = M_NONE;
                else if (hi == 4'hB) m = M_ABY;
                else                 m = odd ? M_ABX : M_ABS;
            end
            default: m = M_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import eag_pkg::*;
(
    input  byte_t      opcode,
    output mode_info_t info
);
    amode_e m;

    always_comb begin
        m         = op_mode(opcode);
        info.mode = m;
        info.wide = (m == M_ABS) || (m == M_ABX) || (m == M_ABY) || (m == M_IND);
        info.fast = (m == M_NONE) || (m == M_IMPL) || (m == M_ACC);
    end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
(
    input  amode_e mode,
    input  byte_t  b0,
    input  byte_t  b1,
    input  byte_t  p0,
    input  byte_t  p1,
    input  addr_t  base_pc,
    input  byte_t  x_idx,
    input  byte_t  y_idx,
    input  logic   carry,
    output addr_t  ea_c,
    output addr_t  ptr_c
);
    localparam byte_t POS_MAX = byte_t'((1 << (DATA_W - 1)) - 1);

    addr_t wide_op;
    addr_t cin;

    always_comb begin
        wide_op = {b0, b1};
        cin     = addr_t'(carry);
        ptr_c   = (mode == M_IND) ? wide_op : zext(b0);
        case (mode)
            M_ABS:   ea_c = wide_op;
            M_ABX:   ea_c = wide_op + zext(x_idx) + cin;
            M_ABY:   ea_c = wide_op + zext(y_idx) + cin;
            M_ZP:    ea_c = zext(b0);
            M_ZPX:   ea_c = zext(b0) + zext(x_idx);
            M_ZPY:   ea_c = zext(b0) + zext(y_idx);
            M_PREX:  ea_c = zext(b0) + zext(x_idx);
            M_POSTY: ea_c = zext(p0) + zext(y_idx) + cin;
            M_IND:   ea_c = {p0, p1};
            M_REL:   ea_c = (b0 <= POS_MAX) ? (base_pc + zext(b0))
                                            : (base_pc + zext(POS_MAX) - zext(b0));
            default: ea_c = '0;
        endcase
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [15:0] pc_in,
    input  logic [7:0]  x_in,
    input  logic [7:0]  y_in,
    input  logic [7:0]  a_in,
    input  logic        carry_in,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [7:0]  mem_rdata,
    output logic        done,
    output logic [15:0] ea,
    output logic [7:0]  operand,
    output logic [15:0] pc_out,
    output logic        bad_mode
);
    mode_info_t dec_info;
    amode_e     mode_q;
    logic       wide_q, c_q;
    step_e      step_q, step_nxt;
    addr_t      pc_q, ea_c, ptr_c, pc_next_c;
    byte_t      x_q, y_q, b0_q, b1_q, p0_q, p1_q, b0_live, fin_operand;
    logic       fin;

    eag_mode_decode u_dec (
        .opcode (opcode),
        .info   (dec_info)
    );

    assign b0_live = (step_q == ST_B0) ? mem_rdata : b0_q;

    eag_addr_calc u_calc (
        .mode    (mode_q),
        .b0      (b0_live),
        .b1      (b1_q),
        .p0      (p0_q),
        .p1      (p1_q),
        .base_pc (pc_q),
        .x_idx   (x_q),
        .y_idx   (y_q),
        .carry   (c_q),
        .ea_c    (ea_c),
        .ptr_c   (ptr_c)
    );

    assign pc_next_c = pc_q + (wide_q ? addr_t'(2) : addr_t'(1));
    assign mem_req   = (step_q != ST_IDLE);

    always_comb begin
        case (step_q)
            ST_B0:    mem_addr = pc_q;
            ST_B1:    mem_addr = pc_q + addr_t'(1);
            ST_P0:    mem_addr = ptr_c;
            ST_P1:    mem_addr = ptr_c + addr_t'(1);
            ST_FIN:   mem_addr = ea_c;
            ST_DEREF: mem_addr = zext(p0_q);
            default:  mem_addr = '0;
        endcase
    end

    always_comb begin
        step_nxt    = step_q;
        fin         = 1'b0;
        fin_operand = mem_rdata;
        case (step_q)
            ST_B0: begin
                if (wide_q)                                step_nxt = ST_B1;
                else if (mode_q == M_IMM)                  fin = 1'b1;
                else if (mode_q == M_REL) begin
                    fin         = 1'b1;
                    fin_operand = '0;
                end
                else if (mode_q == M_POSTY)                step_nxt = ST_P0;
                else                                       step_nxt = ST_FIN;
            end
            ST_B1:    step_nxt = (mode_q == M_IND) ? ST_P0 : ST_FIN;
            ST_P0:    step_nxt = (mode_q == M_IND) ? ST_P1 : ST_FIN;
            ST_P1:    step_nxt = ST_FIN;
            ST_FIN: begin
                if (mode_q == M_PREX) step_nxt = ST_DEREF;
                else                  fin = 1'b1;
            end
            ST_DEREF: fin = 1'b1;
            default:  step_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= ST_IDLE;
            mode_q   <= M_NONE;
            wide_q   <= 1'b0;
            c_q      <= 1'b0;
            pc_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            b0_q     <= '0;
            b1_q     <= '0;
            p0_q     <= '0;
            p1_q     <= '0;
            done     <= 1'b0;
            ea       <= '0;
            operand  <= '0;
            pc_out   <= '0;
            bad_mode <= 1'b0;
        end else begin
            done <= 1'b0;
            if (step_q == ST_IDLE) begin
                if (start) begin
                    mode_q <= dec_info.mode;
                    wide_q <= dec_info.wide;
                    pc_q   <= pc_in;
                    x_q    <= x_in;
                    y_q    <= y_in;
                    c_q    <= carry_in;
                    if (dec_info.fast) begin
                        done     <= 1'b1;
                        ea       <= '0;
                        operand  <= (dec_info.mode == M_ACC) ? a_in : '0;
                        pc_out   <= pc_in;
                        bad_mode <= (dec_info.mode == M_NONE);
                    end else begin
                        step_q <= ST_B0;
                    end
                end
            end else if (mem_rvalid) begin
                case (step_q)
                    ST_B0:   b0_q <= mem_rdata;
                    ST_B1:   b1_q <= mem_rdata;
                    ST_P0:   p0_q <= mem_rdata;
                    ST_P1:   p1_q <= mem_rdata;
                    ST_FIN:  if (mode_q == M_PREX) p0_q <= mem_rdata;
                    default: ;
                endcase
                if (fin) begin
                    step_q   <= ST_IDLE;
                    done     <= 1'b1;
                    ea       <= ea_c;
                    operand  <= fin_operand;
                    pc_out   <= pc_next_c;
                    bad_mode <= 1'b0;
                end else begin
                    step_q <= step_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_rvalid,
    input logic        done,
    input logic [15:0] ea,
    input logic [7:0]  operand,
    input logic [15:0] pc_out,
    input logic        bad_mode
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R11
    req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ea) && $stable(operand) && $stable(pc_out) && $stable(bad_mode)));

    // R10
    bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && bad_mode) |-> (ea == 16'h0 && operand == 8'h0));
endmodule

bind eff_addr_gen eag_chk u_eag_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .ea         (ea),
    .operand    (operand),
    .pc_out     (pc_out),
    .bad_mode   (bad_mode)
);

// File: tb/eff_addr_gen_bench.sv
`timescale 1ns/1ps
module eff_addr_gen_bench;
    localparam int K_NONE = 0, K_IMPL = 1, K_ACC = 2, K_IMM = 3, K_ABS = 4, K_ABX = 5,
                   K_ABY = 6, K_IND = 7, K_PREX = 8, K_POSTY = 9, K_REL = 10,
                   K_ZP = 11, K_ZPX = 12, K_ZPY = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0, y_in = '0, a_in = '0;
    logic        carry_in = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] ea, pc_out;
    logic [7:0]  operand;
    logic        bad_mode;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int lat    = 0;

    logic [15:0] ov_a [4];
    logic [7:0]  ov_d [4];
    bit          ov_on [4];

    always #2.5 clk = ~clk;

    eff_addr_gen u_eff_addr_gen (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .a_in(a_in), .carry_in(carry_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .ea(ea), .operand(operand),
        .pc_out(pc_out), .bad_mode(bad_mode)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        for (int i = 0; i < 4; i++)
            if (ov_on[i] && ov_a[i] == a) return ov_d[i];
        return a[7:0] * 8'd29 + a[15:8] * 8'd7 + 8'h3C;
    endfunction

    // Memory model: random latency of 0..2 extra cycles, valid held one cycle.
    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid = 1'b0;
            lat = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = memf(mem_addr);
                reads++;
                lat = $urandom % 3;
            end else begin
                lat--;
            end
        end
    end

    function automatic int ref_kind(input logic [7:0] op);
        if ((op & 8'h1F) == 8'h10) return K_REL;
        if (op[3:0] == 4'h8) return K_IMPL;
        if (op[3:0] == 4'h1) return op[4] ? K_POSTY : K_PREX;
        if (op[3:0] == 4'h5) return op[4] ? K_ZPX : K_ZP;
        if (op[3:0] == 4'hD) return op[4] ? K_ABX : K_ABS;
        if (op == 8'h96 || op == 8'hB6) return K_ZPY;
        if (op[3:0] == 4'h6) return op[4] ? K_ZPX : K_ZP;
        if (op == 8'h89 || op == 8'h9E) return K_NONE;
        if (op[3:0] == 4'h9) return op[4] ? K_ABY : K_IMM;
        if (op == 8'hBE) return K_ABY;
        if (op[3:0] == 4'hE) return op[4] ? K_ABX : K_ABS;
        if (op == 8'h6C) return K_IND;
        if (op == 8'hBC) return K_ABX;
        if (op == 8'h2C || op == 8'h4C || op == 8'h8C || op == 8'hAC ||
            op == 8'hCC || op == 8'hEC) return K_ABS;
        if (op == 8'h24 || op == 8'h84 || op == 8'hA4 || op == 8'hC4 || op == 8'hE4) return K_ZP;
        if (op == 8'h94 || op == 8'hB4) return K_ZPX;
        if (op == 8'h0A || op == 8'h2A || op == 8'h4A || op == 8'h6A) return K_ACC;
        if (op == 8'h8A || op == 8'h9A || op == 8'hAA || op == 8'hBA ||
            op == 8'hCA || op == 8'hEA) return K_IMPL;
        if (op == 8'hA2 || op == 8'hA0 || op == 8'hC0 || op == 8'hE0) return K_IMM;
        if (op == 8'h20) return K_ABS;
        if (op == 8'h00 || op == 8'h40 || op == 8'h60) return K_IMPL;
        return K_NONE;
    endfunction

    function automatic string req_of(input int k);
        case (k)
            K_ABS, K_IND:          return (k == K_IND) ? "R7" : "R2";
            K_ABX, K_ABY:          return "R3";
            K_ZP, K_ZPX, K_ZPY:    return "R4";
            K_PREX:                return "R5";
            K_POSTY:               return "R6";
            K_REL:                 return "R8";
            K_ACC, K_IMM:          return "R9";
            default:               return "R10";
        endcase
    endfunction

    task automatic expect_of(input logic [7:0] op, input logic [15:0] pc,
                             input logic [7:0] x, input logic [7:0] y,
                             input logic [7:0] a, input logic c,
                             output logic [15:0] e_ea, output logic [7:0] e_op,
                             output logic [15:0] e_pc, output logic e_bad,
                             output int e_n);
        logic [7:0]  b0, b1;
        logic [15:0] p;
        int          k;
        k = ref_kind(op);
        b0 = memf(pc);
        b1 = memf(pc + 16'd1);
        e_ea = 16'h0; e_op = 8'h0; e_pc = pc; e_bad = 1'b0; e_n = 0;
        case (k)
            K_NONE: e_bad = 1'b1;
            K_ACC:  e_op = a;
            K_IMM:  begin e_op = b0; e_pc = pc + 16'd1; e_n = 1; end
            K_REL:  begin
                e_ea = (b0 < 8'd128) ? pc + {8'h0, b0} : pc + 16'd127 - {8'h0, b0};
                e_pc = pc + 16'd1; e_n = 1;
            end
            K_ZP, K_ZPX, K_ZPY: begin
                e_ea = {8'h0, b0} + ((k == K_ZPX) ? {8'h0, x} : (k == K_ZPY) ? {8'h0, y} : 16'h0);
                e_op = memf(e_ea); e_pc = pc + 16'd1; e_n = 2;
            end
            K_ABS, K_ABX, K_ABY: begin
                e_ea = {b0, b1};
                if (k == K_ABX) e_ea = e_ea + {8'h0, x} + {15'h0, c};
                if (k == K_ABY) e_ea = e_ea + {8'h0, y} + {15'h0, c};
                e_op = memf(e_ea); e_pc = pc + 16'd2; e_n = 3;
            end
            K_IND: begin
                p = {b0, b1};
                e_ea = {memf(p), memf(p + 16'd1)};
                e_op = memf(e_ea); e_pc = pc + 16'd2; e_n = 5;
            end
            K_PREX: begin
                e_ea = {8'h0, b0} + {8'h0, x};
                e_op = memf({8'h0, memf(e_ea)}); e_pc = pc + 16'd1; e_n = 3;
            end
            K_POSTY: begin
                e_ea = {8'h0, memf({8'h0, b0})} + {8'h0, y} + {15'h0, c};
                e_op = memf(e_ea); e_pc = pc + 16'd1; e_n = 3;
            end
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one walk; entered at a negedge with the block idle (or with done high).
    task automatic do_op(input logic [7:0] op, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] a, input logic c,
                         input bit poke_busy, input string tag);
        logic [15:0] e_ea, e_pc;
        logic [7:0]  e_op;
        logic        e_bad;
        int          e_n;
        int          cyc;
        string       r;
        expect_of(op, pc, x, y, a, c, e_ea, e_op, e_pc, e_bad, e_n);
        r = (tag != "") ? tag : req_of(ref_kind(op));
        opcode = op; pc_in = pc; x_in = x; y_in = y; a_in = a; carry_in = c;
        reads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opcode = ~op; pc_in = ~pc; x_in = ~x; y_in = ~y; a_in = ~a; carry_in = ~c;
        if (poke_busy && mem_req) begin
            opcode = 8'hEA;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check(r, "timeout", 16'h0, 16'h1);
            return;
        end
        check(r, "ea", ea, e_ea);
        check(r, "operand", {8'h0, operand}, {8'h0, e_op});
        check(r, "pc_out", pc_out, e_pc);
        check(r, "bad_mode", {15'h0, bad_mode}, {15'h0, e_bad});
        check(r, "reads", reads[15:0], e_n[15:0]);
    endtask

    task automatic pulse_gap(input string req);
        @(negedge clk);
        check(req, "done one-cycle", {15'h0, done}, 16'h0);
    endtask

    task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
        ov_a[i] = a; ov_d[i] = d; ov_on[i] = 1'b1;
    endtask

    task automatic clear_ov();
        for (int i = 0; i < 4; i++) ov_on[i] = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        clear_ov();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12", "done", {15'h0, done}, 16'h0);
        check("R12", "mem_req", {15'h0, mem_req}, 16'h0);
        check("R12", "ea", ea, 16'h0);
        check("R12", "pc_out", pc_out, 16'h0);
        check("R12", "operand/bad", {7'h0, bad_mode, operand}, 16'h0);

        // R1 decode corners
        do_op(8'h02, 16'h1234, 8'h11, 8'h22, 8'h33, 1'b1, 0, "R1"); pulse_gap("R11");
        do_op(8'hEA, 16'h1234, 8'h11, 8'h22, 8'h33, 1'b1, 0, "R1"); pulse_gap("R11");
        do_op(8'h0A, 16'h1234, 8'h11, 8'h22, 8'hA5, 1'b0, 0, "R1"); pulse_gap("R11");
        do_op(8'hA9, 16'h2000, 8'h11, 8'h22, 8'h33, 1'b0, 0, "R1");
        do_op(8'h96, 16'h2100, 8'h11, 8'hF0, 8'h33, 1'b1, 0, "R1");
        do_op(8'hB6, 16'h2200, 8'h11, 8'h07, 8'h33, 1'b1, 0, "R1");
        do_op(8'hBE, 16'h2300, 8'h44, 8'h09, 8'h33, 1'b1, 0, "R1");
        do_op(8'h6C, 16'h2400, 8'h11, 8'h22, 8'h33, 1'b0, 0, "R1");
        do_op(8'hD0, 16'h2500, 8'h11, 8'h22, 8'h33, 1'b0, 0, "R1");

        // R8 offset boundaries
        set_ov(0, 16'h4000, 8'h80);
        do_op(8'h30, 16'h4000, 8'h0, 8'h0, 8'h0, 1'b0, 0, "R8");
        check("R8", "offset 0x80 -> base-1", ea, 16'h3FFF);
        set_ov(0, 16'h4000, 8'h7F);
        do_op(8'h10, 16'h4000, 8'h0, 8'h0, 8'h0, 1'b1, 0, "R8");
        check("R8", "offset 0x7F -> base+127", ea, 16'h407F);
        set_ov(0, 16'h4000, 8'hFF);
        do_op(8'hF0, 16'h4000, 8'h0, 8'h0, 8'h0, 1'b0, 0, "R8");
        check("R8", "offset 0xFF -> base-128", ea, 16'h3F80);

        // R4 no wrap into page zero
        set_ov(0, 16'h4100, 8'hF0);
        do_op(8'hB5, 16'h4100, 8'h20, 8'h0, 8'h0, 1'b1, 0, "R4");
        check("R4", "zp+X carries out of page", ea, 16'h0110);

        // R3 carry added, crossing a page
        set_ov(0, 16'h4200, 8'h12);
        set_ov(1, 16'h4201, 8'hFF);
        do_op(8'hBD, 16'h4200, 8'h01, 8'h0, 8'h0, 1'b1, 0, "R3");
        check("R3", "abs+X+carry", ea, 16'h1301);

        // R5 pre-indexed with 16-bit sum
        clear_ov();
        set_ov(0, 16'h4300, 8'hFF);
        set_ov(1, 16'h0101, 8'h55);
        do_op(8'hA1, 16'h4300, 8'h02, 8'h0, 8'h0, 1'b1, 0, "R5");
        check("R5", "ea", ea, 16'h0101);
        check("R5", "second read at 0x0055", {8'h0, operand}, {8'h0, memf(16'h0055)});

        // R6 post-indexed with carry
        clear_ov();
        set_ov(0, 16'h4400, 8'h40);
        set_ov(1, 16'h0040, 8'hFF);
        do_op(8'hB1, 16'h4400, 8'h0, 8'h01, 8'h0, 1'b1, 0, "R6");
        check("R6", "ptr+Y+carry", ea, 16'h0101);

        // R2 program counter wrap
        clear_ov();
        do_op(8'hAD, 16'hFFFF, 8'h0, 8'h0, 8'h0, 1'b0, 0, "R2");

        // R11 start ignored while busy, inputs latched
        do_op(8'h6C, 16'h5000, 8'h3, 8'h4, 8'h5, 1'b1, 1, "R11");
        do_op(8'hB1, 16'h5100, 8'h3, 8'h4, 8'h5, 1'b1, 1, "R11");
        pulse_gap("R11");

        // Random walks, each new start in the cycle done is seen
        for (int i = 0; i < 400; i++) begin
            do_op(8'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                  8'($urandom), 1'($urandom), (i % 7) == 3, "");
            if ((i % 5) == 0) pulse_gap("R11");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule